// File: doc/BRIEF.md
# Global Counter with Compare Channel

This block keeps a 64-bit free-running count of its clock and compares it against a programmable 64-bit target. Software reaches every register through a 32-bit write/read port. Each 64-bit quantity is exposed as two 32-bit halves. The count and the target are each loaded one half at a time. A read returns one half only, and nothing latches the other half at that moment.

When the compare channel is enabled and the count equals the target, a sticky pending flag is raised. An enable bit gates that flag onto the interrupt pin. In one-shot mode the target is left unchanged after a hit. In auto-increment mode the target advances by a programmed step at every hit, so the events recur at a fixed spacing.

Software does not get an acknowledge on the bus. Instead, every write to a key register sets a confirmation bit. Software polls that bit and then clears it by writing 1 to it.

Top module: `gt_timer_top`

## Requirements
- R1: After reset, every register reads 0 and `irq` is 0.
- R2: While control bit 8 is 1, the count rises by one each cycle; while it is 0, the count holds.
- R3: A write to 0x100 replaces the low half of the count and a write to 0x104 replaces the high half. No increment happens in the cycle of that write. A carry out of the low half increments the high half.
- R4: The target halves (0x200 low, 0x204 high), the step (0x208) and the interrupt enable (0x248, bit 0) read back what was written. Control (0x240) keeps bits 8, 1 and 0 only and reads 0 elsewhere.
- R5: When control bit 0 is 1 and the count equals the target, bit 0 of 0x244 is set at the next edge. It stays set until software clears it.
- R6: With control bit 1 at 0 (one-shot), a hit leaves the target unchanged.
- R7: With control bit 1 at 1 (auto-increment), each hit adds the zero-extended step to the target at the same edge that sets the flag.
- R8: Writing 1 to bit 0 of 0x244 clears the flag. A hit in the same cycle wins and the flag stays 1.
- R9: `irq` is registered. Its value equals the flag AND enable bit 0 as they were one cycle earlier.
- R10: One cycle after a write, a bit of 0x24C is set for the register written: bit 0 for 0x200, bit 1 for 0x204, bit 2 for 0x208, and bit 16 for 0x240.
- R11: One cycle after a write, a bit of 0x110 is set for the count half written: bit 0 for 0x100 and bit 1 for 0x104.
- R12: Writing to 0x24C or 0x110 clears each bit written as 1 and leaves the bits written as 0 unchanged.
- R13: `rdata` is registered. It shows the register at the address sampled at the previous edge, taken before that edge's updates. Unmapped addresses read 0. The two count halves are read independently, so a carry between two reads can give a torn value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the current address |
| addr | input | 12 | Register byte address, used for both writes and reads |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Registered compare interrupt |

## Verification
All state changes land at the edge that samples the write or the hit.
- Count, target, flag and confirmation bits are visible on `rdata` one edge after the read address is presented.
- A hit reaches `irq` two edges after the hit condition: one edge for the flag and one edge for the output register.

The bench drives inputs on falling edges. A behavioural model in the bench steps at each rising edge using those same latencies. Both `rdata` and `irq` are compared with the model on every falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/gt_pkg.sv
package gt_pkg;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] A_CNT_LO = 12'h100;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 12'h104;
  localparam logic [ADDR_W-1:0] A_CNT_WS = 12'h110;
  localparam logic [ADDR_W-1:0] A_CMP_LO = 12'h200;
  localparam logic [ADDR_W-1:0] A_CMP_HI = 12'h204;
  localparam logic [ADDR_W-1:0] A_STEP   = 12'h208;
  localparam logic [ADDR_W-1:0] A_CTRL   = 12'h240;
  localparam logic [ADDR_W-1:0] A_ISTAT  = 12'h244;
  localparam logic [ADDR_W-1:0] A_IEN    = 12'h248;
  localparam logic [ADDR_W-1:0] A_WS     = 12'h24C;

  localparam int B_RUN  = 8;
  localparam int B_AUTO = 1;
  localparam int B_CEN  = 0;

  localparam int WS_N      = 17;
  localparam int WS_CMP_LO = 0;
  localparam int WS_CMP_HI = 1;
  localparam int WS_STEP   = 2;
  localparam int WS_CTRL   = 16;

  localparam int WSC_N  = 2;
  localparam int WSC_LO = 0;
  localparam int WSC_HI = 1;
endpackage

// File: rtl/gt_counter.sv
module gt_counter #(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [DW-1:0]   wdata,
  output logic [2*DW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)        cnt <= '0;
    else if (wr_lo) cnt <= {cnt[2*DW-1:DW], wdata};
    else if (wr_hi) cnt <= {wdata, cnt[DW-1:0]};
    else if (run)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/gt_compare.sv
module gt_compare #(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cen,
  input  logic            auto_inc,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic            wr_step,
  input  logic [DW-1:0]   wdata,
  input  logic [2*DW-1:0] cnt,
  output logic [2*DW-1:0] cmp,
  output logic [DW-1:0]   step,
  output logic            hit
);
  localparam int CW = 2 * DW;

  assign hit = cen && (cnt == cmp);

  always_ff @(posedge clk) begin
    if (rst)                  cmp <= '0;
    else if (wr_lo)           cmp <= {cmp[CW-1:DW], wdata};
    else if (wr_hi)           cmp <= {wdata, cmp[DW-1:0]};
    else if (hit && auto_inc) cmp <= cmp + {{DW{1'b0}}, step};
  end

  always_ff @(posedge clk) begin
    if (rst)          step <= '0;
    else if (wr_step) step <= wdata;
  end
endmodule

// File: rtl/gt_wstat.sv
module gt_wstat #(
  parameter int NB = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NB-1:0] set,
  input  logic          clr_wr,
  input  logic [NB-1:0] clr_mask,
  output logic [NB-1:0] bits
);
  for (genvar i = 0; i < NB; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                          bits[i] <= 1'b0;
      else if (set[i])                  bits[i] <= 1'b1;
      else if (clr_wr && clr_mask[i])   bits[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/gt_timer_top.sv
module gt_timer_top
  import gt_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              irq
);
  localparam int CW = 2 * DW;

  logic w_cnt_lo, w_cnt_hi, w_cmp_lo, w_cmp_hi, w_step, w_ctrl;
  logic w_istat, w_ien, w_ws, w_cnt_ws;

  assign w_cnt_lo = wr_en && (addr == A_CNT_LO);
  assign w_cnt_hi = wr_en && (addr == A_CNT_HI);
  assign w_cmp_lo = wr_en && (addr == A_CMP_LO);
  assign w_cmp_hi = wr_en && (addr == A_CMP_HI);
  assign w_step   = wr_en && (addr == A_STEP);
  assign w_ctrl   = wr_en && (addr == A_CTRL);
  assign w_istat  = wr_en && (addr == A_ISTAT);
  assign w_ien    = wr_en && (addr == A_IEN);
  assign w_ws     = wr_en && (addr == A_WS);
  assign w_cnt_ws = wr_en && (addr == A_CNT_WS);

  logic ctrl_run, ctrl_auto, ctrl_cen, ien, istat;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_run  <= 1'b0;
      ctrl_auto <= 1'b0;
      ctrl_cen  <= 1'b0;
    end else if (w_ctrl) begin
      ctrl_run  <= wdata[B_RUN];
      ctrl_auto <= wdata[B_AUTO];
      ctrl_cen  <= wdata[B_CEN];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        ien <= 1'b0;
    else if (w_ien) ien <= wdata[0];
  end

  logic [CW-1:0] cnt, cmp;
  logic [DW-1:0] step;
  logic          hit;

  gt_counter #(.DW(DW)) u_cnt (
    .clk(clk), .rst(rst), .run(ctrl_run),
    .wr_lo(w_cnt_lo), .wr_hi(w_cnt_hi), .wdata(wdata), .cnt(cnt)
  );

  gt_compare #(.DW(DW)) u_cmp (
    .clk(clk), .rst(rst), .cen(ctrl_cen), .auto_inc(ctrl_auto),
    .wr_lo(w_cmp_lo), .wr_hi(w_cmp_hi), .wr_step(w_step),
    .wdata(wdata), .cnt(cnt), .cmp(cmp), .step(step), .hit(hit)
  );

  always_ff @(posedge clk) begin
    if (rst)                      istat <= 1'b0;
    else if (hit)                 istat <= 1'b1;
    else if (w_istat && wdata[0]) istat <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= istat && ien;
  end

  logic [WS_N-1:0]  ws_g_set, ws_g;
  logic [WSC_N-1:0] ws_c_set, ws_c;

  always_comb begin
    ws_g_set            = '0;
    ws_g_set[WS_CMP_LO] = w_cmp_lo;
    ws_g_set[WS_CMP_HI] = w_cmp_hi;
    ws_g_set[WS_STEP]   = w_step;
    ws_g_set[WS_CTRL]   = w_ctrl;
    ws_c_set            = '0;
    ws_c_set[WSC_LO]    = w_cnt_lo;
    ws_c_set[WSC_HI]    = w_cnt_hi;
  end

  gt_wstat #(.NB(WS_N)) u_ws_g (
    .clk(clk), .rst(rst), .set(ws_g_set), .clr_wr(w_ws),
    .clr_mask(wdata[WS_N-1:0]), .bits(ws_g)
  );

  gt_wstat #(.NB(WSC_N)) u_ws_c (
    .clk(clk), .rst(rst), .set(ws_c_set), .clr_wr(w_cnt_ws),
    .clr_mask(wdata[WSC_N-1:0]), .bits(ws_c)
  );

  logic [DW-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_CNT_LO: rd_mux = cnt[DW-1:0];
      A_CNT_HI: rd_mux = cnt[CW-1:DW];
      A_CNT_WS: rd_mux[WSC_N-1:0] = ws_c;
      A_CMP_LO: rd_mux = cmp[DW-1:0];
      A_CMP_HI: rd_mux = cmp[CW-1:DW];
      A_STEP:   rd_mux = step;
      A_CTRL: begin
        rd_mux[B_RUN]  = ctrl_run;
        rd_mux[B_AUTO] = ctrl_auto;
        rd_mux[B_CEN]  = ctrl_cen;
      end
      A_ISTAT:  rd_mux[0] = istat;
      A_IEN:    rd_mux[0] = ien;
      A_WS:     rd_mux[WS_N-1:0] = ws_g;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/gt_timer_chk.sv
module gt_timer_chk
  import gt_pkg::*;
#(
  parameter int DW = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [2*DW-1:0]   cnt,
  input logic [2*DW-1:0]   cmp,
  input logic [DW-1:0]     step,
  input logic              run,
  input logic              cen,
  input logic              auto_inc,
  input logic              stat,
  input logic              en,
  input logic              irq,
  input logic [WS_N-1:0]   ws_g
);
  logic cnt_wr, cmp_wr, hit_now;
  assign cnt_wr  = wr_en && (addr == A_CNT_LO || addr == A_CNT_HI);
  assign cmp_wr  = wr_en && (addr == A_CMP_LO || addr == A_CMP_HI);
  assign hit_now = cen && (cnt == cmp);

  p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
    (run && !cnt_wr) |=> cnt == $past(cnt) + 64'd1);

  p_count_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!run && !cnt_wr) |=> $stable(cnt));

  p_hit_sets_r5: assert property (@(posedge clk) disable iff (rst)
    hit_now |=> stat);

  p_oneshot_keep_r6: assert property (@(posedge clk) disable iff (rst)
    (hit_now && !auto_inc && !cmp_wr) |=> $stable(cmp));

  p_auto_step_r7: assert property (@(posedge clk) disable iff (rst)
    (hit_now && auto_inc && !cmp_wr) |=> cmp == $past(cmp) + {{DW{1'b0}}, $past(step)});

  p_irq_gate_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq == $past(stat && en));

  p_ctrl_ack_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_CTRL) |=> ws_g[WS_CTRL]);
endmodule

bind gt_timer_top gt_timer_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
  .cnt(cnt), .cmp(cmp), .step(step),
  .run(ctrl_run), .cen(ctrl_cen), .auto_inc(ctrl_auto),
  .stat(istat), .en(ien), .irq(irq), .ws_g(ws_g)
);

// File: tb/test_gt_timer_top.sv
`timescale 1ns/1ps
module test_gt_timer_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [11:0] addr = 12'h000;
  logic [31:0] wdata = 32'h0;
  logic [31:0] rdata;
  logic        irq;

  always #2.5 clk = ~clk;

  gt_timer_top i_gt_timer_top (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    started = 1'b0;
  bit    done = 1'b0;

  // behavioural model state
  logic [63:0] m_cnt, m_cmp;
  logic [31:0] m_step;
  logic        m_run, m_auto, m_cen, m_en, m_stat;
  logic [16:0] m_wsg;
  logic [1:0]  m_wsc;
  logic [31:0] exp_rdata;
  logic        exp_irq;

  function automatic logic [31:0] model_read(logic [11:0] a);
    case (a)
      12'h100: return m_cnt[31:0];
      12'h104: return m_cnt[63:32];
      12'h110: return {30'd0, m_wsc};
      12'h200: return m_cmp[31:0];
      12'h204: return m_cmp[63:32];
      12'h208: return m_step;
      12'h240: return {23'd0, m_run, 6'd0, m_auto, m_cen};
      12'h244: return {31'd0, m_stat};
      12'h248: return {31'd0, m_en};
      12'h24C: return {15'd0, m_wsg};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      m_cnt = 0; m_cmp = 0; m_step = 0;
      m_run = 0; m_auto = 0; m_cen = 0; m_en = 0; m_stat = 0;
      m_wsg = 0; m_wsc = 0;
      exp_rdata = 0; exp_irq = 0;
    end else begin
      logic hit;
      exp_rdata = model_read(addr);
      exp_irq   = m_stat & m_en;
      hit = m_cen && (m_cnt == m_cmp);
      if (wr_en && addr == 12'h24C) m_wsg = m_wsg & ~wdata[16:0];
      if (wr_en && addr == 12'h110) m_wsc = m_wsc & ~wdata[1:0];
      if (hit) m_stat = 1;
      else if (wr_en && addr == 12'h244 && wdata[0]) m_stat = 0;
      if (wr_en && addr == 12'h100) begin m_cnt[31:0] = wdata; m_wsc[0] = 1; end
      else if (wr_en && addr == 12'h104) begin m_cnt[63:32] = wdata; m_wsc[1] = 1; end
      else if (m_run) m_cnt = m_cnt + 1;
      if (wr_en && addr == 12'h200) begin m_cmp[31:0] = wdata; m_wsg[0] = 1; end
      else if (wr_en && addr == 12'h204) begin m_cmp[63:32] = wdata; m_wsg[1] = 1; end
      else if (hit && m_auto) m_cmp = m_cmp + {32'd0, m_step};
      if (wr_en && addr == 12'h208) begin m_step = wdata; m_wsg[2] = 1; end
      if (wr_en && addr == 12'h248) m_en = wdata[0];
      if (wr_en && addr == 12'h240) begin
        m_run = wdata[8]; m_auto = wdata[1]; m_cen = wdata[0]; m_wsg[16] = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      checks++;
      if (rdata !== exp_rdata) begin
        errors++;
        $display("FAIL %s rdata got %h expected %h (t=%0t)", cur_req, rdata, exp_rdata, $time);
      end
      checks++;
      if (irq !== exp_irq) begin
        errors++;
        $display("FAIL %s irq got %b expected %b (t=%0t)", cur_req, irq, exp_irq, $time);
      end
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = 32'h0;
  endtask

  task automatic rd(input logic [11:0] a);
    addr = a;
    @(negedge clk);
  endtask

  task automatic rd_all();
    rd(12'h100); rd(12'h104); rd(12'h110); rd(12'h200); rd(12'h204);
    rd(12'h208); rd(12'h240); rd(12'h244); rd(12'h248); rd(12'h24C);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cyc(2);
    rd_all();             // R1: registers during reset
    @(negedge clk) rst = 1'b0;
    cur_req = "R1";
    rd_all();             // R1: state right after reset

    cur_req = "R4";       // readback of target, step, enable, control mask
    wr(12'h200, 32'hDEAD_0001);
    wr(12'h204, 32'h1234_5678);
    wr(12'h208, 32'h0000_0055);
    wr(12'h248, 32'hFFFF_FFFF);
    wr(12'h240, 32'hFFFF_FEFE);
    rd_all();
    cur_req = "R10";      // write confirmations in 0x24C
    rd(12'h24C);
    cur_req = "R12";      // partial clear keeps zero-written bits
    wr(12'h24C, 32'h0000_0005);
    rd(12'h24C);
    wr(12'h24C, 32'hFFFF_FFFF);
    rd(12'h24C);
    wr(12'h248, 32'h0);

    cur_req = "R2";       // run and hold
    wr(12'h240, 32'h100);
    for (int i = 0; i < 6; i++) rd(12'h100);
    wr(12'h240, 32'h0);
    for (int i = 0; i < 4; i++) rd(12'h100);

    cur_req = "R3";       // half writes and carry across halves
    wr(12'h100, 32'hFFFF_FFF8);
    wr(12'h104, 32'h0000_0001);
    cur_req = "R11";
    rd(12'h110);
    wr(12'h110, 32'h1);
    rd(12'h110);
    wr(12'h110, 32'h2);
    rd(12'h110);
    cur_req = "R13";      // independent half reads across the carry
    wr(12'h240, 32'h100);
    for (int i = 0; i < 6; i++) begin rd(12'h100); rd(12'h104); end
    rd(12'h3F0);
    cur_req = "R3";
    wr(12'h100, 32'h0000_0010);  // write during run replaces, no increment
    rd(12'h100);

    cur_req = "R5";       // one-shot hit
    wr(12'h240, 32'h0);
    wr(12'h100, 32'h0);
    wr(12'h104, 32'h0);
    wr(12'h200, 32'd20);
    wr(12'h204, 32'h0);
    wr(12'h248, 32'h1);
    wr(12'h240, 32'h101);
    for (int i = 0; i < 28; i++) rd(12'h244);
    cur_req = "R6";
    rd(12'h200); rd(12'h204);
    cur_req = "R9";
    wr(12'h248, 32'h0);
    cyc(3);
    wr(12'h248, 32'h1);
    cyc(3);
    cur_req = "R8";
    wr(12'h244, 32'h1);
    rd(12'h244); cyc(3);

    cur_req = "R7";       // auto-increment recurrence
    wr(12'h240, 32'h0);
    wr(12'h100, 32'h0);
    wr(12'h200, 32'd12);
    wr(12'h208, 32'd7);
    wr(12'h240, 32'h103);
    for (int i = 0; i < 5; i++) begin
      rd(12'h200); cyc(2);
      wr(12'h244, 32'h1);
      rd(12'h244);
    end

    cur_req = "R8";       // hit every cycle: clear loses to hit
    wr(12'h240, 32'h0);
    wr(12'h208, 32'd1);
    wr(12'h100, 32'd100);
    wr(12'h200, 32'd104);
    wr(12'h240, 32'h103);
    cyc(8);
    wr(12'h244, 32'h1);
    rd(12'h244); rd(12'h244);
    wr(12'h240, 32'h100);
    wr(12'h244, 32'h1);
    rd(12'h244); cyc(3);

    finish_run();
  end
endmodule